// File: doc/BRIEF.md
# Quad DAC SPI Frame Engine

The block sits between a local host and the serial port of a four-channel digital-to-analog converter. It turns a single register-level request, given with an address, a 16-bit value and a read/write flag, into the 24-bit SPI frames the converter expects. It handles all of the chip-select, clock and shift timing.

A write sends one frame. A read sends two frames. The first is a read-request frame. Chip select then goes high for a guard interval. The second frame carries a fixed no-operation word, and the converter shifts out the answer during it. The engine keeps the low half of the word received in that second frame and returns it to the host.

A write can also be marked as an indirect control write. For such a write the engine builds the per-channel control address itself and packs a 3-bit sub-register selector above a 13-bit payload. The serial clock comes from the system clock through a parameterised divider and runs in SPI mode 0.

Top module: `dac_frame_engine`

## Requirements
- R1: After reset `csN` is 1, `sclk` is 0, and both `busy` and `done` are 0.
- R2: A plain write (`reqWrite`=1, `reqCtrl`=0) sends exactly one chip-select frame of 24 bits, most significant bit first, with these bit positions:
  - bit 23 is 0;
  - bits 22:21 are 0;
  - bits 20:16 hold `reqAddr`;
  - bits 15:0 hold `reqData`.
- R3: A control write (`reqWrite`=1, `reqCtrl`=1) sends one frame with these bit positions:
  - bits 20:16 hold address 0x1C plus channel `reqAddr[1:0]`;
  - bits 15:13 hold `reqSel`;
  - bits 12:0 hold `reqData[12:0]`;
  - bit 23 and bits 22:21 are 0.
- R4: A read (`reqWrite`=0) sends two chip-select frames:
  - the first has bit 23 set, `reqAddr` in bits 20:16, and zero in every other bit;
  - the second is the constant 0x1CE000.
  - `reqCtrl` has no effect on a read.
- R5: Between the two frames of a read, `csN` stays high for 4*HALF_DIV system clock cycles. That is two SPI clock periods.
- R6: With `done`, `rdData` presents bits 15:0 of the 24-bit word sampled on `miso` during the second frame of a read.
- R7: `busy` rises only on the cycle after a request is accepted and stays high until the `done` cycle. A `reqValid` seen while `busy` is high is dropped and produces no frame.
- R8: `done` is a single-cycle pulse after the last frame of every request.
- R9: SPI mode 0 clocking:
  - `sclk` is low whenever `csN` is high;
  - each high phase of `sclk` lasts HALF_DIV system clock cycles;
  - `miso` is sampled when `sclk` rises.
- R10: While `csN` stays low, `mosi` changes only on the cycle in which `sclk` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCtrl | input | 1 | With a write: build an indirect control write |
| reqSel | input | 3 | Control sub-register selector (0 slew, 1 main, 2 DAC control, 3 DC-DC, 4 software) |
| reqAddr | input | 5 | Register address; bits 1:0 give the channel for control writes |
| reqData | input | 16 | Write data or control payload |
| busy | output | 1 | A transaction is in flight |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read result, valid with `done` |
| sclk | output | 1 | SPI clock, idle low |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |

## Verification
Plain writes, control writes and reads are mixed at random over the full address and data space. The same random values are fed to the slave model's reply word. Plain writes and control writes on the same address show whether the selector and payload packing replaces the raw data field. Reads show whether the read flag is set, whether the constant second word is sent, and whether the answer is taken from the second frame rather than the first. Directed cases cover:
- all-ones and all-zero data;
- every selector value;
- a read with the control flag set;
- a request issued during a transfer, which must leave the frame count unchanged.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;
  localparam int FRAME_W = 24;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int SEL_W   = 3;
  localparam int PAY_W   = DATA_W - SEL_W;
  localparam logic [FRAME_W-1:0] NOOP_WORD = 24'h1CE000;
  localparam logic [ADDR_W-1:0]  CTRL_BASE = 5'h1C;

  typedef struct packed {
    logic load;      // load a new frame into the shifter
    logic loadNoop;  // with load: use the no-op word
    logic run;       // chip select active, clock running
    logic capture;   // latch the received low half
  } dp_cmd_t;

  function automatic logic [FRAME_W-1:0] buildFrame(
      input logic isWrite, input logic isCtrl, input logic [SEL_W-1:0] sel,
      input logic [ADDR_W-1:0] addr, input logic [DATA_W-1:0] data);
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    if (!isWrite) begin
      a = addr;
      d = '0;
    end else if (isCtrl) begin
      a = CTRL_BASE | {3'b000, addr[1:0]};
      d = {sel, data[PAY_W-1:0]};
    end else begin
      a = addr;
      d = data;
    end
    return {~isWrite, 2'b00, a, d};
  endfunction
endpackage

// File: rtl/dac_spi_datapath.sv
module dac_spi_datapath
  import dac_spi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_cmd_t           cmd,
  input  logic              reqWrite,
  input  logic              reqCtrl,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              frameEnd,
  output logic [DATA_W-1:0] rdData
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] txShift, rxShift;
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic               halfTick;

  assign halfTick = (divCnt == DIV_W'(HALF_DIV - 1));
  assign frameEnd = cmd.run && sclk && halfTick && (bitCnt == BIT_W'(FRAME_W - 1));
  assign mosi     = txShift[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      sclk    <= 1'b0;
      rdData  <= '0;
    end else begin
      if (cmd.load) begin
        txShift <= cmd.loadNoop ? NOOP_WORD
                                : buildFrame(reqWrite, reqCtrl, reqSel, reqAddr, reqData);
        divCnt  <= '0;
        bitCnt  <= '0;
        sclk    <= 1'b0;
      end else if (cmd.run) begin
        if (halfTick) begin
          divCnt <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rxShift <= {rxShift[FRAME_W-2:0], miso};
          end else begin
            sclk    <= 1'b0;
            txShift <= {txShift[FRAME_W-2:0], 1'b0};
            bitCnt  <= bitCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end else begin
        divCnt <= '0;
        sclk   <= 1'b0;
      end
      if (cmd.capture) rdData <= rxShift[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/dac_spi_ctrl.sv
module dac_spi_ctrl
  import dac_spi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    frameEnd,
  output dp_cmd_t cmd,
  output logic    busy,
  output logic    done
);
  localparam int GAP_CYC = 4 * HALF_DIV;
  localparam int GAP_W   = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FR1, ST_GAP, ST_FR2} state_t;

  state_t           state;
  logic             isRead;
  logic [GAP_W-1:0] gapCnt;
  logic             accept, gapLast;

  assign accept  = reqValid && (state == ST_IDLE);
  assign gapLast = (state == ST_GAP) && (gapCnt == GAP_W'(GAP_CYC - 1));
  assign busy    = (state != ST_IDLE);

  always_comb begin
    cmd.load     = accept || gapLast;
    cmd.loadNoop = (state == ST_GAP);
    cmd.run      = (state == ST_FR1) || (state == ST_FR2);
    cmd.capture  = (state == ST_FR2) && frameEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isRead <= 1'b0;
      gapCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_FR1;
          isRead <= !reqWrite;
        end
        ST_FR1: if (frameEnd) begin
          if (isRead) begin
            state  <= ST_GAP;
            gapCnt <= '0;
          end else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        ST_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapLast) state <= ST_FR2;
        end
        ST_FR2: if (frameEnd) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_frame_engine.sv
module dac_frame_engine
  import dac_spi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqCtrl,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  dp_cmd_t cmd;
  logic    frameEnd;

  dac_spi_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .frameEnd(frameEnd), .cmd(cmd), .busy(busy), .done(done)
  );

  dac_spi_datapath #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqWrite(reqWrite), .reqCtrl(reqCtrl),
    .reqSel(reqSel), .reqAddr(reqAddr), .reqData(reqData), .miso(miso),
    .sclk(sclk), .mosi(mosi), .frameEnd(frameEnd), .rdData(rdData)
  );

  assign csN = !cmd.run;
endmodule

// File: rtl/dac_frame_engine_chk.sv
module dac_frame_engine_chk #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic csN,
  input logic mosi
);
  logic        sclkQ;
  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      runLen <= 16'd1;
    end else begin
      sclkQ  <= sclk;
      runLen <= (sclk != sclkQ) ? 16'd1 : runLen + 16'd1;
    end
  end

  // R9
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);
  // R9
  high_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclk && sclkQ) |-> (runLen == 16'(HALF_DIV)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
  // R7
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && !$fell(sclk)) |-> $stable(mosi));
endmodule

bind dac_frame_engine dac_frame_engine_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .sclk(sclk), .csN(csN), .mosi(mosi)
);

// File: tb/tb_dac_frame_engine.sv
module tb_dac_frame_engine;
  localparam int HALF_DIV = 2;
  localparam int GAP_CYC  = 4 * HALF_DIV;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqCtrl = 1'b0;
  logic [2:0] reqSel = '0;
  logic [4:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic busy, done, sclk, csN, mosi;
  logic miso = 1'b0;
  logic [15:0] rdData;

  int checks = 0, fails = 0;
  logic [23:0] frames [0:7];
  int frameBits [0:7];
  int frameCnt = 0;
  int curBits = 0;
  logic [23:0] curWord = '0;
  logic [23:0] respWord = '0;
  int respIdx = 0;
  realtime csHighAt = 0;
  int lastGap = 0;

  always #4 clk = ~clk;

  dac_frame_engine #(.HALF_DIV(HALF_DIV)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCtrl(reqCtrl), .reqSel(reqSel), .reqAddr(reqAddr), .reqData(reqData),
    .busy(busy), .done(done), .rdData(rdData), .sclk(sclk), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  // slave model: capture mosi on rising sclk, shift respWord out on miso
  always @(negedge csN) begin
    curBits = 0;
    curWord = '0;
    miso = respWord[23];
    respIdx = 22;
    if (frameCnt > 0) lastGap = int'(($realtime - csHighAt) / 8.0);
  end
  always @(posedge sclk) begin
    curWord = {curWord[22:0], mosi};
    curBits++;
  end
  always @(negedge sclk) begin
    if (!csN && respIdx >= 0) begin
      miso = respWord[respIdx];
      respIdx--;
    end
  end
  always @(posedge csN) begin
    if (rstN) begin
      if (frameCnt < 8) begin
        frames[frameCnt] = curWord;
        frameBits[frameCnt] = curBits;
      end
      frameCnt++;
      csHighAt = $realtime;
    end
  end

  function automatic logic [23:0] expFrame(input logic w, input logic c,
      input logic [2:0] s, input logic [4:0] a, input logic [15:0] d);
    if (!w) return {1'b1, 2'b00, a, 16'h0000};
    if (c) return {1'b0, 2'b00, 3'b111, a[1:0], s, d[12:0]};
    return {1'b0, 2'b00, a, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic runReq(input logic w, input logic c, input logic [2:0] s,
      input logic [4:0] a, input logic [15:0] d, input logic [23:0] resp,
      input bit injectBusy);
    int n;
    logic [23:0] f0;
    respWord = resp;
    frameCnt = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqCtrl = c; reqSel = s; reqAddr = a; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy === 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
    if (injectBusy) begin
      repeat (20) @(negedge clk);
      reqValid = 1'b1; reqWrite = 1'b1; reqCtrl = 1'b0; reqAddr = 5'h03; reqData = 16'hBEEF;
      @(negedge clk);
      reqValid = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
      if (done !== 1'b1)
        check(busy === 1'b1, "R7 busy held", 32'(busy), 32'd1);
    end
    check(done === 1'b1, "R8 done seen", 32'(done), 32'd1);
    check(busy === 1'b0, "R7 busy low at done", 32'(busy), 32'd0);
    if (!w) check(rdData == resp[15:0], "R6 read result", 32'(rdData), 32'(resp[15:0]));
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", 32'(done), 32'd0);
    if (injectBusy) begin
      repeat (60) @(negedge clk);
      check(csN === 1'b1, "R7 no frame from dropped request", 32'(csN), 32'd1);
    end
    f0 = expFrame(w, c, s, a, d);
    check(frameCnt == (w ? 1 : 2), w ? "R2/R3 frame count" : "R4 frame count",
          32'(frameCnt), w ? 32'd1 : 32'd2);
    check(frameBits[0] == 24, "R2 frame length", 32'(frameBits[0]), 32'd24);
    check(frames[0] == f0, w ? (c ? "R3 control frame" : "R2 write frame") : "R4 read request",
          32'(frames[0]), 32'(f0));
    if (!w) begin
      check(frames[1] == 24'h1CE000, "R4 no-op frame", 32'(frames[1]), 32'h1CE000);
      check(lastGap >= GAP_CYC, "R5 chip select gap", 32'(lastGap), 32'(GAP_CYC));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(csN === 1'b1 && sclk === 1'b0, "R1 spi idle", {30'd0, csN, sclk}, 32'd2);
    check(busy === 1'b0 && done === 1'b0, "R1 host idle", {30'd0, busy, done}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    runReq(1'b1, 1'b0, 3'd0, 5'h1F, 16'hFFFF, 24'h0, 1'b0);        // R2 all ones
    runReq(1'b1, 1'b0, 3'd0, 5'h00, 16'h0000, 24'h0, 1'b0);        // R2 all zero
    for (int s = 0; s < 5; s++)
      runReq(1'b1, 1'b1, 3'(s), 5'(s), 16'hA5A5, 24'h0, 1'b0);     // R3 each selector
    runReq(1'b0, 1'b0, 3'd0, 5'h19, 16'h1234, 24'hC3F00D, 1'b0);   // R4 R6
    runReq(1'b0, 1'b1, 3'd7, 5'h05, 16'hFFFF, 24'h00FFFF, 1'b0);   // R4 ctrl ignored on read
    runReq(1'b1, 1'b0, 3'd0, 5'h02, 16'h8001, 24'h0, 1'b1);        // R7 dropped request
    runReq(1'b0, 1'b0, 3'd0, 5'h1A, 16'h0, 24'hFF0000, 1'b1);      // R7 during read
    // constrained random mix
    for (int i = 0; i < 40; i++) begin
      logic w, c;
      w = 1'($urandom_range(0, 2) != 0);
      c = 1'($urandom_range(0, 1));
      runReq(w, c, 3'($urandom_range(0, 4)), 5'($urandom_range(0, 31)),
             16'($urandom), 24'($urandom), 1'b0);
    end
    finishRun();
  end
endmodule